// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox

This block carries short command words between two ports that run on unrelated clocks, alongside a data queue that lives outside it. Port A owns one register, the forward box, which port A fills and port B drains. Port B owns the return box, which port B fills and port A drains. Each box has an active-low full flag held in its writer's domain. The flag blocks any overwrite until the reader has drained the word.

Each port presents a chip select (active low), an enable, a read/write level and a mailbox select. A transfer with the mailbox select high goes to a box, and one with it low is left to the external queue. A drain is signalled to the writer by toggling an acknowledge bit. That bit crosses into the writer's domain through a two-flop synchronizer, so the flag returns high only once the acknowledge has arrived there. Reading a box does not change its contents. Port B's read data is registered and is steered between the external queue output and the forward box. Port A's read data is always the return box.

Top module: `dual_clock_mailbox`

## Requirements
- R1: A port-A operation with a_sel_n=0, a_en=1, a_wr=1 (write level) and a_mbox=1 while a_full_n=1 loads a_wdata into the forward box and drives a_full_n low at that clk_a edge.
- R2: A port-B operation with b_sel_n=0, b_en=1, b_wr=1 and b_mbox=1 while b_full_n=1 loads b_wdata into the return box and drives b_full_n low at that clk_b edge.
- R3: A mailbox write while that box's flag is low is ignored: the stored word and the flag are unchanged.
- R4: A port-B mailbox read (b_sel_n=0, b_en=1, b_wr=0, b_mbox=1) of a pending word returns a_full_n high once the acknowledge has crossed into clk_a, within 8 clk_a cycles, and never at the edge of the read itself. A port-A mailbox read (a_wr=0, a_mbox=1) does the same for b_full_n.
- R5: b_rdata is registered on clk_b and shows, one edge after sampling, fifo_rdata when b_mbox=0 and the forward box when b_mbox=1.
- R6: a_rdata is registered on clk_a and always shows the return box one edge later.
- R7: A read leaves a box's contents unchanged, and a repeated read returns the same word. A read with no word pending does not change the flag.
- R8: With rst_a and rst_b held high, both flags read 1, both boxes and both read-data outputs read 0.
- R9: An operation with chip select high or enable low neither writes nor drains a box.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Synchronous active-high reset, clk_a domain |
| a_sel_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A level: 1 write, 0 read |
| a_mbox | input | 1 | Port A mailbox select |
| a_wdata | input | W | Port A write word |
| a_rdata | output | W | Return box contents, registered |
| a_full_n | output | 1 | Forward box flag, low when full |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Synchronous active-high reset, clk_b domain |
| b_sel_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B level: 1 write, 0 read |
| b_mbox | input | 1 | Port B mailbox select |
| b_wdata | input | W | Port B write word |
| fifo_rdata | input | W | Output word of the external queue |
| b_rdata | output | W | Port B read word, registered |
| b_full_n | output | 1 | Return box flag, low when full |

## Verification
The assertions check on every edge that an accepted write loads the word and lowers its flag, that a box changes only on an accepted write (so blocked writes, reads and deselected cycles leave it alone), and that port B's queue path follows fifo_rdata. The flag's return after a cross-domain drain depends on the phase of two unrelated clocks, so only the bench's round trips show it. The same holds for the word actually arriving on the far port, the overwrite blocking as seen from the reader, and the non-destructive repeated read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic WR_LEVEL = 1'b1;
  localparam int unsigned MIN_SYNC = 2;

  typedef struct packed {
    logic mb_wr;
    logic mb_rd;
  } mbx_op_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
(
  input  logic    sel_n,
  input  logic    en,
  input  logic    wr,
  input  logic    mbox,
  output mbx_op_t op
);
  logic active;

  always_comb begin
    active   = !sel_n && en && mbox;
    op.mb_wr = active && (wr == WR_LEVEL);
    op.mb_rd = active && (wr != WR_LEVEL);
  end
endmodule

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned N = (STAGES < mbx_pkg::MIN_SYNC) ? mbx_pkg::MIN_SYNC : STAGES;

  logic [N-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[N-2:0], d};
  end

  assign q = shift_q[N-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned W      = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  output logic         full_n,
  output logic [W-1:0] mail_q,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         rd_req
);
  logic req_t;
  logic ack_t;
  logic ack_in_w;
  logic req_in_r;
  logic pending_r;

  // writer domain: storage, request toggle, flag
  always_ff @(posedge wclk) begin
    if (wrst) begin
      mail_q <= '0;
      req_t  <= 1'b0;
      full_n <= 1'b1;
    end else if (wr_req && full_n) begin
      mail_q <= wdata;
      req_t  <= ~req_t;
      full_n <= 1'b0;
    end else if (!full_n && (ack_in_w == req_t)) begin
      full_n <= 1'b1;
    end
  end

  mbx_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk (wclk),
    .rst (wrst),
    .d   (ack_t),
    .q   (ack_in_w)
  );

  mbx_sync #(.STAGES(STAGES)) u_req_sync (
    .clk (rclk),
    .rst (rrst),
    .d   (req_t),
    .q   (req_in_r)
  );

  // reader domain: acknowledge toggle, only for a word that has arrived
  assign pending_r = (req_in_r != ack_t);

  always_ff @(posedge rclk) begin
    if (rrst)                       ack_t <= 1'b0;
    else if (rd_req && pending_r)   ack_t <= ~ack_t;
  end
endmodule

// File: rtl/dual_clock_mailbox.sv
module dual_clock_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned W      = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_a,
  input  logic         rst_a,
  input  logic         a_sel_n,
  input  logic         a_en,
  input  logic         a_wr,
  input  logic         a_mbox,
  input  logic [W-1:0] a_wdata,
  output logic [W-1:0] a_rdata,
  output logic         a_full_n,
  input  logic         clk_b,
  input  logic         rst_b,
  input  logic         b_sel_n,
  input  logic         b_en,
  input  logic         b_wr,
  input  logic         b_mbox,
  input  logic [W-1:0] b_wdata,
  input  logic [W-1:0] fifo_rdata,
  output logic [W-1:0] b_rdata,
  output logic         b_full_n
);
  mbx_op_t     op_a;
  mbx_op_t     op_b;
  logic [W-1:0] mail1_q;
  logic [W-1:0] mail2_q;

  mbx_port_decode u_dec_a (
    .sel_n (a_sel_n), .en (a_en), .wr (a_wr), .mbox (a_mbox), .op (op_a)
  );

  mbx_port_decode u_dec_b (
    .sel_n (b_sel_n), .en (b_en), .wr (b_wr), .mbox (b_mbox), .op (op_b)
  );

  // forward box: written on A, drained on B
  mbx_channel #(.W(W), .STAGES(STAGES)) u_fwd (
    .wclk   (clk_a),
    .wrst   (rst_a),
    .wr_req (op_a.mb_wr),
    .wdata  (a_wdata),
    .full_n (a_full_n),
    .mail_q (mail1_q),
    .rclk   (clk_b),
    .rrst   (rst_b),
    .rd_req (op_b.mb_rd)
  );

  // return box: written on B, drained on A
  mbx_channel #(.W(W), .STAGES(STAGES)) u_ret (
    .wclk   (clk_b),
    .wrst   (rst_b),
    .wr_req (op_b.mb_wr),
    .wdata  (b_wdata),
    .full_n (b_full_n),
    .mail_q (mail2_q),
    .rclk   (clk_a),
    .rrst   (rst_a),
    .rd_req (op_a.mb_rd)
  );

  always_ff @(posedge clk_a) begin
    if (rst_a) a_rdata <= '0;
    else       a_rdata <= mail2_q;
  end

  always_ff @(posedge clk_b) begin
    if (rst_b)       b_rdata <= '0;
    else if (b_mbox) b_rdata <= mail1_q;
    else             b_rdata <= fifo_rdata;
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned W = 36
) (
  input logic         clk_a,
  input logic         rst_a,
  input logic         a_sel_n,
  input logic         a_en,
  input logic         a_wr,
  input logic         a_mbox,
  input logic [W-1:0] a_wdata,
  input logic         a_full_n,
  input logic         clk_b,
  input logic         rst_b,
  input logic         b_sel_n,
  input logic         b_en,
  input logic         b_wr,
  input logic         b_mbox,
  input logic [W-1:0] b_wdata,
  input logic [W-1:0] fifo_rdata,
  input logic [W-1:0] b_rdata,
  input logic         b_full_n,
  input logic [W-1:0] mail1,
  input logic [W-1:0] mail2
);
  logic a_put;
  logic b_put;
  assign a_put = !a_sel_n && a_en && a_wr && a_mbox;
  assign b_put = !b_sel_n && b_en && b_wr && b_mbox;

  a_r1_load: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_put && a_full_n) |=> (!a_full_n && mail1 == $past(a_wdata)));

  a_r2_load: assert property (@(posedge clk_b) disable iff (rst_b)
    (b_put && b_full_n) |=> (!b_full_n && mail2 == $past(b_wdata)));

  a_r3_block_a: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_put && !a_full_n) |=> (!a_full_n && $stable(mail1)));

  a_r3_block_b: assert property (@(posedge clk_b) disable iff (rst_b)
    (b_put && !b_full_n) |=> (!b_full_n && $stable(mail2)));

  // R7, R9: no accepted write means the box keeps its word
  a_r7_keep_a: assert property (@(posedge clk_a) disable iff (rst_a)
    !(a_put && a_full_n) |=> $stable(mail1));

  a_r7_keep_b: assert property (@(posedge clk_b) disable iff (rst_b)
    !(b_put && b_full_n) |=> $stable(mail2));

  a_r5_queue_path: assert property (@(posedge clk_b) disable iff (rst_b)
    !b_mbox |=> (b_rdata == $past(fifo_rdata)));
endmodule

bind dual_clock_mailbox mbx_checker #(.W(W)) u_chk (
  .clk_a (clk_a), .rst_a (rst_a), .a_sel_n (a_sel_n), .a_en (a_en),
  .a_wr (a_wr), .a_mbox (a_mbox), .a_wdata (a_wdata), .a_full_n (a_full_n),
  .clk_b (clk_b), .rst_b (rst_b), .b_sel_n (b_sel_n), .b_en (b_en),
  .b_wr (b_wr), .b_mbox (b_mbox), .b_wdata (b_wdata),
  .fifo_rdata (fifo_rdata), .b_rdata (b_rdata), .b_full_n (b_full_n),
  .mail1 (mail1_q), .mail2 (mail2_q)
);

// File: tb/dual_clock_mailbox_test.sv
module dual_clock_mailbox_test;
  localparam int W = 36;
  localparam int NV = 6;
  // {direction (0: A to B, 1: B to A), word}
  localparam logic [W:0] VEC [NV] = '{
    {1'b0, 36'h0_1234_5678}, {1'b1, 36'hF_FFFF_FFFF}, {1'b0, 36'hA_5A5A_5A5A},
    {1'b1, 36'h5_A5A5_A5A5}, {1'b0, 36'h8_0000_0001}, {1'b1, 36'h0_0000_0000}
  };

  logic clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1;
  logic a_sel_n = 1, a_en = 0, a_wr = 0, a_mbox = 0;
  logic b_sel_n = 1, b_en = 0, b_wr = 0, b_mbox = 0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0, fifo_rdata = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic a_full_n, b_full_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_a = ~clk_a;
  always #3 clk_b = ~clk_b;

  dual_clock_mailbox #(.W(W)) uut (
    .clk_a, .rst_a, .a_sel_n, .a_en, .a_wr, .a_mbox, .a_wdata, .a_rdata, .a_full_n,
    .clk_b, .rst_b, .b_sel_n, .b_en, .b_wr, .b_mbox, .b_wdata, .fifo_rdata,
    .b_rdata, .b_full_n
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(logic sel_n, logic en, logic wr, logic mb, logic [W-1:0] d);
    @(negedge clk_a);
    a_sel_n = sel_n; a_en = en; a_wr = wr; a_mbox = mb; a_wdata = d;
    @(negedge clk_a);
    a_sel_n = 1; a_en = 0; a_wr = 0;
  endtask

  task automatic b_op(logic sel_n, logic en, logic wr, logic mb, logic [W-1:0] d);
    @(negedge clk_b);
    b_sel_n = sel_n; b_en = en; b_wr = wr; b_mbox = mb; b_wdata = d;
    @(negedge clk_b);
    b_sel_n = 1; b_en = 0; b_wr = 0;
  endtask

  task automatic wait_flag_a(string req);
    int n = 0;
    while (!a_full_n && n < 8) begin @(negedge clk_a); n++; end
    check(req, W'(a_full_n), W'(1));
  endtask

  task automatic wait_flag_b(string req);
    int n = 0;
    while (!b_full_n && n < 8) begin @(negedge clk_a); n++; end
    check(req, W'(b_full_n), W'(1));
  endtask

  initial begin
    repeat (60000) @(posedge clk_a);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk_b);
    // R8 reset state
    check("R8 a_full_n", W'(a_full_n), W'(1));
    check("R8 b_full_n", W'(b_full_n), W'(1));
    check("R8 a_rdata", a_rdata, '0);
    check("R8 b_rdata", b_rdata, '0);
    @(negedge clk_a) rst_a = 0;
    @(negedge clk_b) rst_b = 0;
    fifo_rdata = 36'h3_3333_3333;

    // table of round trips (R1 R2 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      if (!VEC[i][W]) begin
        a_op(0, 1, 1, 1, VEC[i][W-1:0]);
        check("R1 flag low", W'(a_full_n), W'(0));
        repeat (4) @(negedge clk_b);
        b_mbox = 1;
        b_op(0, 1, 0, 1, '0);
        check("R5 mail path", b_rdata, VEC[i][W-1:0]);
        check("R4 not early", W'(a_full_n), W'(0));
        b_mbox = 0;
        wait_flag_a("R4 flag return a");
      end else begin
        b_op(0, 1, 1, 1, VEC[i][W-1:0]);
        b_mbox = 0;
        check("R2 flag low", W'(b_full_n), W'(0));
        repeat (4) @(negedge clk_a);
        a_op(0, 1, 0, 1, '0);
        check("R6 return path", a_rdata, VEC[i][W-1:0]);
        wait_flag_b("R4 flag return b");
      end
    end

    // R5 queue path with b_mbox low
    fifo_rdata = 36'hC_0FFE_E000;
    @(negedge clk_b); @(negedge clk_b);
    check("R5 queue path", b_rdata, 36'hC_0FFE_E000);

    // R3 overwrite blocked
    a_op(0, 1, 1, 1, 36'h1_1111_1111);
    a_op(0, 1, 1, 1, 36'h2_2222_2222);
    repeat (4) @(negedge clk_b);
    b_mbox = 1;
    b_op(0, 1, 0, 1, '0);
    check("R3 first word kept", b_rdata, 36'h1_1111_1111);
    // R7 repeated read, no pending word
    wait_flag_a("R4 after blocked write");
    b_op(0, 1, 0, 1, '0);
    check("R7 reread same word", b_rdata, 36'h1_1111_1111);
    repeat (6) @(negedge clk_a);
    check("R7 flag unchanged", W'(a_full_n), W'(1));

    // R9 deselected or disabled write
    a_op(1, 1, 1, 1, 36'h7_7777_7777);
    a_op(0, 0, 1, 1, 36'h7_7777_7777);
    check("R9 flag stays high", W'(a_full_n), W'(1));
    @(negedge clk_b); @(negedge clk_b);
    check("R9 word kept", b_rdata, 36'h1_1111_1111);
    b_mbox = 0;

    // R9 disabled drain leaves the flag low
    b_op(0, 1, 1, 1, 36'h9_9999_9999);
    repeat (4) @(negedge clk_a);
    a_op(0, 0, 0, 1, '0);
    repeat (8) @(negedge clk_a);
    check("R9 drain ignored", W'(b_full_n), W'(0));
    check("R6 word visible", a_rdata, 36'h9_9999_9999);
    a_op(0, 1, 0, 1, '0);
    wait_flag_b("R4 drain b");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule